// File: doc/BRIEF.md
# Character LCD Host Write Controller

This block sits between a simple request source and a character LCD module that has a parallel bus. A client hands it one byte at a time over a valid/ready handshake, with a flag that marks the byte as a display character or as a controller command. The block then runs the bus on its own. It first reads the module's status register and repeats that read until the busy flag on DB7 is clear. Only then does it write the byte to the command register or to the character register.

Every bus transfer has the same shape. The register select, the read/write level and the data lines are set first. The enable strobe then goes high for a fixed number of cycles. The module latches on the falling edge of the strobe, and the block keeps the bus steady for a hold time afterwards. The setup, strobe and hold times are parameters counted in clock cycles. The host drives the data lines only while a write transfer is in progress and releases them for status reads.

A mode input chooses the bus width for each request: the full 8-bit bus, or a 4-bit bus that uses only DB7 to DB4. In 4-bit mode every byte, and every status read, takes two transfers. If the module stays busy past a cycle limit (about 2 ms worth of cycles by default), the write goes ahead anyway and a one-cycle error flag is raised.

Top module: `charlcd_writer`

## Requirements
- R1: While reset is held and right after it, lcd_en is 0, lcd_db_oe is 0 and wr_ready is 1.
- R2: Before each write, the block reads status with lcd_rs=0 and lcd_rw=1, and lcd_db_oe stays 0 throughout every status read.
- R3: The block issues no write until a status read has returned DB7=0. When the module reports busy on N consecutive status reads, the block performs exactly N+1 status reads before the write.
- R4: A write drives lcd_rw=0 and lcd_db_oe=1. It uses lcd_rs=0 for a command and lcd_rs=1 for a character. In 8-bit mode the whole byte appears on DB7..DB0, and a command such as 0x80 passes through unchanged.
- R5: In 4-bit mode a byte is written as two transfers, the high nibble first and then the low nibble, each on DB7..DB4 with DB3..DB0 driven to 0.
- R6: In 4-bit mode each status poll takes two read transfers, and the busy flag is taken from DB7 of the first of the two.
- R7: lcd_rs, lcd_rw and the data lines are steady for at least SETUP_CYC cycles before lcd_en rises. lcd_en stays high for exactly PULSE_CYC cycles. The lines stay steady for at least HOLD_CYC cycles after lcd_en falls.
- R8: If the busy flag is still set once BUSY_LIMIT cycles have passed since the request was accepted, the write proceeds and busy_stuck pulses high for exactly one cycle during that request. Otherwise busy_stuck stays 0.
- R9: wr_ready drops in the cycle after a request is accepted and stays low until the write completes. nib_mode is sampled only when a request is accepted, so changing it later has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Request present |
| wr_ready | output | 1 | Block idle; a request is accepted on this cycle |
| wr_is_char | input | 1 | 1 = character register, 0 = command register |
| wr_byte | input | 8 | Byte to write |
| nib_mode | input | 1 | 1 = 4-bit bus, 0 = 8-bit bus, sampled on accept |
| lcd_rs | output | 1 | Register select to the module |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe; the module latches on its falling edge |
| lcd_db_out | output | 8 | Data lines driven by the host |
| lcd_db_oe | output | 1 | Output enable for lcd_db_out |
| lcd_db_in | input | 8 | Data lines as read from the module |
| busy_stuck | output | 1 | One-cycle flag: busy timeout, write forced |

## Verification
A request is accepted at one rising edge, and wr_ready is low from the next cycle on. The first status strobe rises SETUP_CYC+1 cycles after acceptance. Each later transfer starts two cycles after the previous hold time ends, so the absolute timing depends on how many polls the module answers busy. The bench therefore does not wait a fixed number of cycles. It samples every pin on the falling clock edge, measures setup, strobe width and hold around each strobe edge, and compares each completed write against the scoreboard entry queued when the request was sent. That entry carries the expected register, byte, number of status reads and number of timeout flags.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

  // One bus transfer as requested by the sequencer
  typedef struct packed {
    logic       rs;
    logic       rw;
    logic [7:0] data;
  } xfer_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_A,
    SQ_RD_B,
    SQ_WR_A,
    SQ_WR_B
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD
  } phase_e;

  localparam xfer_t STATUS_RD = '{rs: 1'b0, rw: 1'b1, data: 8'h00};

endpackage

// File: rtl/charlcd_xfer.sv
module charlcd_xfer
  import charlcd_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 12,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  xfer_t      req,
  input  logic [7:0] db_in,
  output logic       en,
  output logic       rs,
  output logic       rw,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic       bf,
  output logic       done
);

  localparam int TMAX1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int TMAX  = (TMAX1 > HOLD_CYC) ? TMAX1 : HOLD_CYC;
  localparam int CW    = $clog2(TMAX + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      en     <= 1'b0;
      rs     <= 1'b0;
      rw     <= 1'b0;
      db_out <= '0;
      db_oe  <= 1'b0;
      bf     <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          rs     <= req.rs;
          rw     <= req.rw;
          db_out <= req.rw ? 8'h00 : req.data;
          db_oe  <= ~req.rw;
          cnt    <= CW'(SETUP_CYC - 1);
          ph     <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          en  <= 1'b1;
          cnt <= CW'(PULSE_CYC - 1);
          ph  <= PH_HIGH;
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt == '0) begin
          en  <= 1'b0;
          bf  <= db_in[7];
          cnt <= CW'(HOLD_CYC - 1);
          ph  <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          db_oe <= 1'b0;
          done  <= 1'b1;
          ph    <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Status bits below DB7 (address counter) are not used by this block
  logic ign_unused;
  assign ign_unused = ^db_in[6:0];

endmodule

// File: rtl/charlcd_watch.sv
module charlcd_watch #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/charlcd_writer.sv
module charlcd_writer
  import charlcd_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 12,
  parameter int HOLD_CYC   = 2,
  parameter int BUSY_LIMIT = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_is_char,
  input  logic [7:0] wr_byte,
  input  logic       nib_mode,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [7:0] lcd_db_in,
  output logic       busy_stuck
);

  seq_state_e st;
  logic       start;
  xfer_t      xreq;
  logic [7:0] byte_q;
  logic       char_q;
  logic       m4_q;
  logic       bf_q;
  logic       x_done;
  logic       x_bf;
  logic       expired;
  xfer_t      first_wr;
  xfer_t      second_wr;

  // Write beats: full byte in 8-bit mode, high nibble then low nibble in 4-bit mode
  always_comb begin
    first_wr  = '{rs: char_q, rw: 1'b0, data: m4_q ? {byte_q[7:4], 4'h0} : byte_q};
    second_wr = '{rs: char_q, rw: 1'b0, data: {byte_q[3:0], 4'h0}};
  end

  assign wr_ready = (st == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      start      <= 1'b0;
      xreq       <= '0;
      byte_q     <= '0;
      char_q     <= 1'b0;
      m4_q       <= 1'b0;
      bf_q       <= 1'b0;
      busy_stuck <= 1'b0;
    end else begin
      start      <= 1'b0;
      busy_stuck <= 1'b0;
      unique case (st)
        SQ_IDLE: if (wr_valid) begin
          byte_q <= wr_byte;
          char_q <= wr_is_char;
          m4_q   <= nib_mode;
          xreq   <= STATUS_RD;
          start  <= 1'b1;
          st     <= SQ_RD_A;
        end
        SQ_RD_A: if (x_done) begin
          if (m4_q) begin
            bf_q  <= x_bf;
            xreq  <= STATUS_RD;
            start <= 1'b1;
            st    <= SQ_RD_B;
          end else if (x_bf && !expired) begin
            xreq  <= STATUS_RD;
            start <= 1'b1;
          end else begin
            busy_stuck <= x_bf;
            xreq       <= first_wr;
            start      <= 1'b1;
            st         <= SQ_WR_A;
          end
        end
        SQ_RD_B: if (x_done) begin
          if (bf_q && !expired) begin
            xreq  <= STATUS_RD;
            start <= 1'b1;
            st    <= SQ_RD_A;
          end else begin
            busy_stuck <= bf_q;
            xreq       <= first_wr;
            start      <= 1'b1;
            st         <= SQ_WR_A;
          end
        end
        SQ_WR_A: if (x_done) begin
          if (m4_q) begin
            xreq  <= second_wr;
            start <= 1'b1;
            st    <= SQ_WR_B;
          end else st <= SQ_IDLE;
        end
        SQ_WR_B: if (x_done) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  charlcd_xfer #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_xfer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .req   (xreq),
    .db_in (lcd_db_in),
    .en    (lcd_en),
    .rs    (lcd_rs),
    .rw    (lcd_rw),
    .db_out(lcd_db_out),
    .db_oe (lcd_db_oe),
    .bf    (x_bf),
    .done  (x_done)
  );

  charlcd_watch #(
    .LIMIT(BUSY_LIMIT)
  ) u_watch (
    .clk    (clk),
    .rst    (rst),
    .clear  (st == SQ_IDLE),
    .run    (st != SQ_IDLE),
    .expired(expired)
  );

endmodule

// File: rtl/charlcd_chk.sv
module charlcd_chk #(
  parameter int PULSE_CYC = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_en,
  input logic [7:0] lcd_db_out,
  input logic       lcd_db_oe,
  input logic       busy_stuck
);

  logic [31:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst) hi_len <= '0;
    else if (lcd_en) hi_len <= hi_len + 1'b1;
    else hi_len <= '0;
  end

  a_r7_frozen_while_strobe: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw) &&
                                   $stable(lcd_db_out) && $stable(lcd_db_oe)));

  a_r7_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> (hi_len == PULSE_CYC));

  a_r2_bus_released_on_read: assert property (@(posedge clk) disable iff (rst)
    lcd_rw |-> !lcd_db_oe);

  a_r4_bus_driven_on_write: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && !lcd_rw) |-> lcd_db_oe);

  a_r9_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    busy_stuck |=> !busy_stuck);

  a_r8_only_in_request: assert property (@(posedge clk) disable iff (rst)
    busy_stuck |-> !wr_ready);

endmodule

bind charlcd_writer charlcd_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .lcd_rs    (lcd_rs),
  .lcd_rw    (lcd_rw),
  .lcd_en    (lcd_en),
  .lcd_db_out(lcd_db_out),
  .lcd_db_oe (lcd_db_oe),
  .busy_stuck(busy_stuck)
);

// File: tb/charlcd_writer_test.sv
module charlcd_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int SU  = 2;
  localparam int PW  = 3;
  localparam int HO  = 2;
  localparam int LIM = 300;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_is_char = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       nib_mode = 1'b0;
  logic       lcd_rs, lcd_rw, lcd_en, lcd_db_oe, busy_stuck;
  logic [7:0] lcd_db_out;
  logic [7:0] lcd_db_in;

  always #(CLK_PERIOD / 2) clk = ~clk;

  charlcd_writer #(
    .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HO), .BUSY_LIMIT(LIM)
  ) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_is_char(wr_is_char), .wr_byte(wr_byte), .nib_mode(nib_mode),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_db_out(lcd_db_out),
    .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in), .busy_stuck(busy_stuck)
  );

  typedef struct {
    bit       m4;
    bit       rs;
    bit [7:0] b;
    int       polls;
    int       errs;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // LCD model state
  int   busy_left = 0;
  bit   mdl4 = 1'b0;
  bit   rd_ph = 1'b0;
  bit   wr_ph = 1'b0;
  bit [3:0] hi_nib;

  // Busy on DB7 of the first (or only) status transfer; address bits nonzero
  always_comb begin
    if (lcd_rw && !lcd_db_oe) begin
      if (!mdl4) lcd_db_in = {busy_left > 0, 7'h15};
      else if (!rd_ph) lcd_db_in = {busy_left > 0, 3'b001, 4'h0};
      else lcd_db_in = {4'h5, 4'h0};
    end else lcd_db_in = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: sampled on the falling clock edge
  bit [10:0] prev_sig;
  bit        prev_en = 1'b0;
  int        stab = 0, hw = 0, hcnt = 0, reads = 0, errs = 0;
  bit        htrk = 1'b0;
  exp_t      e;

  always @(negedge clk) begin
    if (rst) begin
      prev_sig = '0; prev_en = 1'b0; stab = 0; hw = 0; htrk = 1'b0;
      reads = 0; errs = 0; rd_ph = 1'b0; wr_ph = 1'b0;
    end else begin
      automatic bit [10:0] sig = {lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out};
      automatic bit chg = (sig != prev_sig);
      if (busy_stuck) errs++;
      if (chg) stab = 0; else stab++;
      if (lcd_en) hw++;
      if (lcd_en && !prev_en) begin
        chk(stab >= SU, "R7 setup", stab, SU);
        htrk = 1'b0;
      end else if (!lcd_en && prev_en) begin
        chk(hw == PW, "R7 strobe width", hw, PW);
        hw = 0; htrk = 1'b1; hcnt = 1;
        if (lcd_rw) begin
          chk(!lcd_db_oe && !lcd_rs, "R2 status read releases bus", lcd_db_oe, 0);
          reads++;
          if (!mdl4 || !rd_ph) begin
            if (busy_left > 0) busy_left--;
          end
          if (mdl4) rd_ph = ~rd_ph;
        end else begin
          chk(lcd_db_oe, "R4 write drives bus", lcd_db_oe, 1);
          if (mdl4 && !wr_ph) begin
            chk(lcd_db_out[3:0] == 4'h0, "R5 low lines zero", lcd_db_out[3:0], 0);
            hi_nib = lcd_db_out[7:4];
            wr_ph = 1'b1;
          end else begin
            automatic bit [7:0] got = mdl4 ? {hi_nib, lcd_db_out[7:4]} : lcd_db_out;
            if (mdl4) chk(lcd_db_out[3:0] == 4'h0, "R5 low lines zero", lcd_db_out[3:0], 0);
            wr_ph = 1'b0;
            if (q.size() == 0) chk(1'b0, "R4 unexpected write", got, -1);
            else begin
              e = q.pop_front();
              chk(lcd_rs == e.rs, "R4 register select", lcd_rs, e.rs);
              chk(got == e.b, e.m4 ? "R5 nibble byte" : "R4 byte", got, e.b);
              if (e.polls >= 0)
                chk(reads == (e.polls + 1) * (e.m4 ? 2 : 1),
                    e.m4 ? "R6 status transfers" : "R3 status reads",
                    reads, (e.polls + 1) * (e.m4 ? 2 : 1));
              chk(errs == e.errs, "R8 timeout flag", errs, e.errs);
            end
            reads = 0; errs = 0;
          end
        end
      end else if (htrk && !lcd_en) begin
        if (chg) begin
          chk(hcnt >= HO, "R7 hold", hcnt, HO);
          htrk = 1'b0;
        end else hcnt++;
      end
      prev_sig = sig;
      prev_en  = lcd_en;
    end
  end

  // Driver: queue the expectation, present the request, wait for completion
  task automatic send(input bit ischar, input bit [7:0] b, input bit m4, input int polls);
    exp_t it;
    do @(negedge clk); while (!wr_ready);
    mdl4      = m4;
    busy_left = (polls < 0) ? 1000000 : polls;
    it.m4 = m4; it.rs = ischar; it.b = b; it.polls = polls; it.errs = (polls < 0) ? 1 : 0;
    q.push_back(it);
    wr_valid = 1'b1; wr_is_char = ischar; wr_byte = b; nib_mode = m4;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(!wr_ready, "R9 ready drops after accept", wr_ready, 0);
    nib_mode = ~m4;   // R9: must not affect the request in flight
    wr_byte  = ~b;
    do @(negedge clk); while (q.size() != 0 || !wr_ready);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!lcd_en && !lcd_db_oe && wr_ready, "R1 state in reset", {lcd_en, lcd_db_oe, wr_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!lcd_en && !lcd_db_oe && wr_ready, "R1 state after reset", {lcd_en, lcd_db_oe, wr_ready}, 1);

    send(1'b0, 8'h80, 1'b0, 0);   // R4 address-set command, 8-bit
    send(1'b1, 8'h41, 1'b0, 3);   // R3 busy for three polls
    send(1'b0, 8'h01, 1'b1, 0);   // R5 4-bit command
    send(1'b1, 8'hA5, 1'b1, 2);   // R6 4-bit with busy polls
    send(1'b1, 8'h3C, 1'b1, 0);   // R9 mode toggled after accept
    send(1'b1, 8'h7E, 1'b0, -1);  // R8 timeout, 8-bit
    send(1'b0, 8'hC3, 1'b1, -1);  // R8 timeout, 4-bit
    send(1'b1, 8'hFF, 1'b0, 1);   // R3 after timeout, no flag
    repeat (5) @(negedge clk);
    chk(q.size() == 0 && wr_ready, "R9 idle at end", q.size(), 0);
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    report();
  end

endmodule